// File: doc/BRIEF.md
# Interrupt and Break Entry Sequencer

This block is the part of an 8-bit CPU core that carries out the common seven-cycle entry sequence used by four causes. The causes are the software break opcode, the maskable interrupt request, the non-maskable interrupt and reset. While it runs, it owns the memory bus. It fetches the opcode, and for break it steps the program counter. It pushes the return address and a status byte onto the stack page, or only reads those locations on reset. It then reads a two-byte handler vector. It hands the core a new program counter, stack pointer and interrupt-disable flag. The first handler opcode fetch falls in the eighth cycle.

The core pulses `boundary` in the cycle before an instruction fetch. At that point the sequencer chooses what to do. A pending reset comes first, then a latched NMI, then an unmasked IRQ. If none of these is present, the sequencer fetches the opcode itself. If that byte is the break opcode, the sequence runs to the end. If it is any other byte, the sequencer releases the bus after the single fetch cycle so that the core can decode it. Reset entry starts on its own in the first cycle after `rst` falls.

Top module: `irq_entry_seq`

## Requirements
- R1: Every complete entry lasts exactly seven cycles with `active` high. In the eighth cycle `active` is low, `addr` equals the handler address and `pc_out` holds the same value.
- R2: For a break, cycle 1 reads the opcode address and cycle 2 reads that address plus 1. The pushed return address is the opcode address plus 2, written high byte first.
- R3: For IRQ and NMI, cycles 1 and 2 both read the current PC. The pushed return address is that PC unchanged.
- R4: The status byte is written in cycle 5. It copies `p_in` bits 7, 6, 3, 2, 1 and 0, forces bit 5 to 1, and sets bit 4 to 1 only for a break. The pushed copy carries the old interrupt-disable value, and `iflag_out` is 1 after every entry.
- R5: The handler vector is read low byte then high byte: 0xFFFE/0xFFFF for IRQ and break, 0xFFFA/0xFFFB for NMI, and 0xFFFC/0xFFFD for reset.
- R6: While `rst` is high, `active` and `we` are low. Reset entry starts in the first cycle after `rst` falls. It keeps `we` low in every cycle, yet `sp_out` ends 3 below `sp_in`, modulo 256.
- R7: If an NMI edge has been latched before a break's cycle 6, the break reads the NMI vector. Its pushed status byte still has bit 4 set, and that NMI is then consumed.
- R8: When `p_in` bit 2 is 1, a low `irq_n` does not start an entry. A break opcode and an NMI still enter.
- R9: An NMI is latched on a falling edge of `nmi_n` only, so a line held low enters once. An NMI takes priority over an IRQ requested at the same boundary.
- R10: At a boundary with no interrupt, a fetched byte other than 0x00 ends the sequence after cycle 1, with no write and with `pc_out` equal to the fetched address plus 1.
- R11: Pushes go to address 0x0100 plus the stack pointer, which decrements after each push and wraps from 0x00 to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; reset entry runs after release |
| boundary | input | 1 | Instruction boundary: the next cycle is an opcode fetch |
| irq_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, active on falling edge |
| p_in | input | 8 | Current flags N V - - D I Z C |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 8 | Current stack pointer |
| rdata | input | 8 | Read data from memory |
| addr | output | 16 | Bus address |
| wdata | output | 8 | Write data |
| we | output | 1 | Write enable |
| active | output | 1 | Sequencer owns the bus |
| pc_out | output | 16 | Updated program counter |
| sp_out | output | 8 | Updated stack pointer |
| iflag_out | output | 1 | Updated interrupt-disable flag |

## Verification
The assertions guard properties that hold on every cycle. Every write lands in the stack page. Reset never writes. An IRQ never starts while masked. An NMI entry always reads the NMI vector. A completed entry always leaves the stack pointer three lower. The push order, the exact return address for break versus interrupts, the bits of the status byte, the NMI takeover of a running break, edge-only NMI latching and the early release on a non-break opcode depend on what memory holds and on when the request lines toggle. Only the bench's directed scenarios can show these, by comparing the recorded bus cycles with the expected ones.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    C_BRK = 2'd0,
    C_IRQ = 2'd1,
    C_NMI = 2'd2,
    C_RST = 2'd3
  } cause_t;
endpackage

// File: rtl/irq_seq_arb.sv
// Request latching and cause selection at an instruction boundary.
module irq_seq_arb
  import irq_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   nmi_n,
  input  logic   irq_n,
  input  logic   iflag,
  input  logic   rst_claim,
  input  logic   nmi_claim,
  output cause_t pick,
  output logic   nmi_pend,
  output logic   rst_pend
);
  logic nmi_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_prev <= 1'b1;
      nmi_pend <= 1'b0;
      rst_pend <= 1'b1;
    end else begin
      nmi_prev <= nmi_n;
      // A new falling edge wins over a claim in the same cycle (R9)
      nmi_pend <= (nmi_pend & ~nmi_claim) | (nmi_prev & ~nmi_n);
      if (rst_claim) rst_pend <= 1'b0;
    end
  end

  // Priority order: reset, NMI, unmasked IRQ, then the break candidate
  always_comb begin
    if (rst_pend)                pick = C_RST;
    else if (nmi_pend)           pick = C_NMI;
    else if (!irq_n && !iflag)   pick = C_IRQ;
    else                         pick = C_BRK;
  end
endmodule

// File: rtl/irq_seq_frame.sv
// Builds the pushed status byte and selects the handler vector.
module irq_seq_frame
  import irq_seq_pkg::*;
#(
  parameter int          AW      = 16,
  parameter int          DW      = 8,
  parameter logic [15:0] VEC_NMI = 16'hFFFA,
  parameter logic [15:0] VEC_RST = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ = 16'hFFFE
) (
  input  cause_t        cause,
  input  logic [DW-1:0] flags,
  input  logic          nmi_pend,
  output logic [DW-1:0] status,
  output logic [AW-1:0] vec_lo,
  output logic          use_nmi
);
  always_comb begin
    status    = flags;
    status[5] = 1'b1;
    status[4] = (cause == C_BRK);
  end

  assign use_nmi = (cause == C_NMI) || (cause == C_BRK && nmi_pend);

  always_comb begin
    if (cause == C_RST) vec_lo = AW'(VEC_RST);
    else if (use_nmi)   vec_lo = AW'(VEC_NMI);
    else                vec_lo = AW'(VEC_IRQ);
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [7:0]  STK_PAGE = 8'h01,
  parameter logic [7:0]  BRK_OPC  = 8'h00,
  parameter logic [15:0] VEC_NMI  = 16'hFFFA,
  parameter logic [15:0] VEC_RST  = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ  = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boundary,
  input  logic          irq_n,
  input  logic          nmi_n,
  input  logic [DW-1:0] p_in,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          we,
  output logic          active,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] sp_out,
  output logic          iflag_out
);
  localparam int CW = 3;
  localparam int IB = 2;   // interrupt-disable bit position

  cause_t        pick, cause_r;
  logic          nmi_pend, rst_pend, use_nmi, start;
  logic [CW-1:0] cyc;
  logic [AW-1:0] pc_r, vec_lo, pc_nx;
  logic [DW-1:0] sp_r, sp0, p_r, status, lo_r;
  logic          i_r;

  assign start = !rst && !active && (rst_pend || boundary);

  irq_seq_arb u_arb (
    .clk(clk), .rst(rst), .nmi_n(nmi_n), .irq_n(irq_n), .iflag(p_in[IB]),
    .rst_claim(start && pick == C_RST),
    .nmi_claim(active && cyc == CW'(5) && use_nmi),
    .pick(pick), .nmi_pend(nmi_pend), .rst_pend(rst_pend)
  );

  irq_seq_frame #(.AW(AW), .DW(DW), .VEC_NMI(VEC_NMI), .VEC_RST(VEC_RST),
                  .VEC_IRQ(VEC_IRQ)) u_frame (
    .cause(cause_r), .flags(p_r), .nmi_pend(nmi_pend),
    .status(status), .vec_lo(vec_lo), .use_nmi(use_nmi)
  );

  assign pc_nx = (cause_r == C_BRK) ? pc_r + AW'(1) : pc_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc <= '0; active <= 1'b0; we <= 1'b0;
      addr <= '0; wdata <= '0; pc_r <= '0; sp_r <= '0; sp0 <= '0;
      p_r <= '0; lo_r <= '0; i_r <= 1'b1; cause_r <= C_RST;
    end else if (start) begin
      cause_r <= pick; pc_r <= pc_in; sp_r <= sp_in; sp0 <= sp_in;
      p_r <= p_in; i_r <= p_in[IB];
      addr <= pc_in; we <= 1'b0; cyc <= CW'(1); active <= 1'b1;
    end else if (active) begin
      case (cyc)
        CW'(1): begin
          if (cause_r == C_BRK && rdata != BRK_OPC) begin
            pc_r <= pc_r + AW'(1);          // not a break: release (R10)
            addr <= pc_r + AW'(1);
            active <= 1'b0; cyc <= '0;
          end else begin
            pc_r <= pc_nx; addr <= pc_nx; cyc <= CW'(2);
          end
        end
        CW'(2): begin
          pc_r  <= pc_nx;
          addr  <= {STK_PAGE, sp_r};
          wdata <= pc_nx[AW-1:DW];
          we    <= (cause_r != C_RST);
          cyc   <= CW'(3);
        end
        CW'(3): begin
          sp_r <= sp_r - DW'(1); addr <= {STK_PAGE, sp_r - DW'(1)};
          wdata <= pc_r[DW-1:0]; cyc <= CW'(4);
        end
        CW'(4): begin
          sp_r <= sp_r - DW'(1); addr <= {STK_PAGE, sp_r - DW'(1)};
          wdata <= status; cyc <= CW'(5);
        end
        CW'(5): begin
          sp_r <= sp_r - DW'(1); we <= 1'b0; i_r <= 1'b1;
          addr <= vec_lo; cyc <= CW'(6);
        end
        CW'(6): begin
          lo_r <= rdata; addr <= addr | AW'(1); cyc <= CW'(7);
        end
        default: begin
          pc_r <= {rdata, lo_r}; addr <= {rdata, lo_r};
          active <= 1'b0; cyc <= '0;
        end
      endcase
    end
  end

  assign pc_out    = pc_r;
  assign sp_out    = sp_r;
  assign iflag_out = i_r;

  a_r11_write_in_stack_page: assert property (@(posedge clk) disable iff (rst)
    we |-> addr[AW-1:DW] == STK_PAGE);
  a_r6_reset_never_writes: assert property (@(posedge clk) disable iff (rst)
    (active && cause_r == C_RST) |-> !we);
  a_r8_irq_not_when_masked: assert property (@(posedge clk) disable iff (rst)
    (start && pick == C_IRQ) |-> !p_in[IB]);
  a_r5_nmi_reads_nmi_vector: assert property (@(posedge clk) disable iff (rst)
    (active && cyc == CW'(6) && cause_r == C_NMI) |-> addr == AW'(VEC_NMI));
  a_r6_sp_three_lower: assert property (@(posedge clk) disable iff (rst)
    ($fell(active) && $past(cyc) == CW'(7)) |-> sp_r == sp0 - DW'(3));
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  logic clk = 1'b0, rst = 1'b1, boundary = 1'b0, irq_n = 1'b1, nmi_n = 1'b1;
  logic [7:0] p_in = '0, sp_in = 8'hFF, rdata;
  logic [15:0] pc_in = '0, addr, pc_out;
  logic [7:0] wdata, sp_out;
  logic we, active, iflag_out;

  irq_entry_seq u_dut (.clk(clk), .rst(rst), .boundary(boundary), .irq_n(irq_n),
    .nmi_n(nmi_n), .p_in(p_in), .pc_in(pc_in), .sp_in(sp_in), .rdata(rdata),
    .addr(addr), .wdata(wdata), .we(we), .active(active), .pc_out(pc_out),
    .sp_out(sp_out), .iflag_out(iflag_out));

  always #2 clk = ~clk;

  // Memory model: vectors, stack page, one opcode location, else 0xEA
  logic [7:0] stk [256];
  logic [7:0] vecm [8];
  logic [15:0] op_addr = '0;
  logic [7:0] op_val = 8'hEA;
  always_comb begin
    if (addr >= 16'hFFF8)           rdata = vecm[addr[2:0]];
    else if (addr[15:8] == 8'h01)   rdata = stk[addr[7:0]];
    else if (addr == op_addr)       rdata = op_val;
    else                            rdata = 8'hEA;
  end
  always @(posedge clk) if (we) stk[addr[7:0]] <= wdata;

  int total = 0, bad = 0, n = 0;
  bit done = 0;
  logic [15:0] la [1:16];
  logic [7:0]  ld [1:16];
  logic        lw [1:16];
  logic [15:0] a8;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Record bus cycles while active; optionally drop NMI during cycle 2.
  task automatic record(input bit hijack);
    n = 0;
    while (active && n < 16) begin
      n++;
      la[n] = addr; ld[n] = wdata; lw[n] = we;
      if (hijack && n == 2) nmi_n = 1'b0;
      @(negedge clk);
    end
    a8 = addr;
  endtask

  task automatic kick(input bit hijack);
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    record(hijack);
  endtask

  task automatic chk_push(input string req, input logic [7:0] sp,
                          input logic [15:0] ret, input logic [7:0] st);
    chk({req, " hi addr"}, la[3], {8'h01, sp});
    chk({req, " hi data"}, ld[3], ret[15:8]);
    chk({req, " lo addr"}, la[4], {8'h01, sp - 8'd1});
    chk({req, " lo data"}, ld[4], ret[7:0]);
    chk({req, " st addr"}, la[5], {8'h01, sp - 8'd2});
    chk({req, " st data"}, ld[5], st);
    chk({req, " writes"}, {lw[3], lw[4], lw[5], lw[6], lw[7]}, 5'b11100);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R6 idle in reset", {active, we}, 0);
    sp_in = 8'h01; pc_in = 16'h0777; p_in = 8'h00;
    rst = 1'b0;
    @(negedge clk);
    record(1'b0);
    chk("R1 reset length", n, 7);
    for (int k = 1; k <= 7; k++) chk("R6 reset no write", lw[k], 0);
    chk("R11 reset addr c3", la[3], 16'h0101);
    chk("R11 reset addr c5", la[5], 16'h01FF);
    chk("R5 reset vec lo", la[6], 16'hFFFC);
    chk("R5 reset vec hi", la[7], 16'hFFFD);
    chk("R6 reset sp wrap", sp_out, 8'hFE);
    chk("R1 reset pc", pc_out, 16'hD022);
    chk("R1 reset fetch addr", a8, 16'hD022);
  endtask

  task automatic t_brk;
    pc_in = 16'h1234; op_addr = 16'h1234; op_val = 8'h00;
    sp_in = 8'hFF; p_in = 8'hC3;
    kick(1'b0);
    chk("R1 brk length", n, 7);
    chk("R2 brk c1 addr", la[1], 16'h1234);
    chk("R2 brk c2 addr", la[2], 16'h1235);
    chk_push("R2 R4 brk", 8'hFF, 16'h1236, 8'hF3);
    chk("R5 brk vec", la[6], 16'hFFFE);
    chk("R1 brk pc", pc_out, 16'hE033);
    chk("R4 brk iflag", iflag_out, 1);
    chk("R11 brk sp", sp_out, 8'hFC);
  endtask

  task automatic t_irq_wrap;
    pc_in = 16'h2000; op_addr = 16'h0000; sp_in = 8'h01; p_in = 8'h08;
    irq_n = 1'b0;
    kick(1'b0);
    irq_n = 1'b1;
    chk("R1 irq length", n, 7);
    chk("R3 irq c1", la[1], 16'h2000);
    chk("R3 irq c2", la[2], 16'h2000);
    chk_push("R3 R4 R11 irq", 8'h01, 16'h2000, 8'h28);
    chk("R11 irq wrap addr", la[5], 16'h01FF);
    chk("R5 irq pc", pc_out, 16'hE033);
    chk("R4 irq iflag", iflag_out, 1);
  endtask

  task automatic t_masked;
    pc_in = 16'h3000; sp_in = 8'hF0; p_in = 8'h04; irq_n = 1'b0;
    kick(1'b0);
    chk("R8 R10 masked irq length", n, 1);
    chk("R10 no write", lw[1], 0);
    chk("R10 pc plus one", pc_out, 16'h3001);
    op_addr = 16'h3100; op_val = 8'h00; pc_in = 16'h3100;
    kick(1'b0);
    irq_n = 1'b1;
    chk("R8 brk while masked length", n, 7);
    chk("R8 R4 brk masked status", ld[5], 8'h34);
    chk("R8 brk masked vec", la[6], 16'hFFFE);
  endtask

  task automatic t_nmi;
    op_addr = 16'h0000; pc_in = 16'h4000; sp_in = 8'hFF; p_in = 8'h04;
    nmi_n = 1'b0; irq_n = 1'b0;
    @(negedge clk);
    kick(1'b0);
    irq_n = 1'b1;
    chk("R9 nmi length", n, 7);
    chk_push("R3 R4 R8 nmi", 8'hFF, 16'h4000, 8'h24);
    chk("R5 nmi vec lo", la[6], 16'hFFFA);
    chk("R5 nmi vec hi", la[7], 16'hFFFB);
    chk("R5 nmi pc", pc_out, 16'hC011);
    pc_in = 16'h4100;
    kick(1'b0);
    chk("R9 held low no retrigger", n, 1);
    nmi_n = 1'b1;
  endtask

  task automatic t_hijack;
    pc_in = 16'h5000; op_addr = 16'h5000; op_val = 8'h00;
    sp_in = 8'h80; p_in = 8'h00;
    kick(1'b1);
    nmi_n = 1'b1;
    chk("R7 hijack length", n, 7);
    chk("R7 hijack vec", la[6], 16'hFFFA);
    chk("R7 hijack status b", ld[5], 8'h30);
    chk("R7 hijack pc", pc_out, 16'hC011);
    pc_in = 16'h5100;
    kick(1'b0);
    chk("R7 nmi consumed", n, 1);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) stk[k] = 8'h00;
    vecm[0] = 8'h00; vecm[1] = 8'h00;
    vecm[2] = 8'h11; vecm[3] = 8'hC0;
    vecm[4] = 8'h22; vecm[5] = 8'hD0;
    vecm[6] = 8'h33; vecm[7] = 8'hE0;
    repeat (3) @(negedge clk);
    t_reset();
    t_brk();
    t_irq_wrap();
    t_masked();
    t_nmi();
    t_hijack();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule